// File: doc/BRIEF.md
# Indirect Host Port Address-Counter Bridge

This block connects an 8080-style indirect host port to an internal memory-and-register bus. The host never presents an address on pins. It writes two command words with the data/command select low. Those words carry a space select (memory or register), a 19-bit start address and an access width (byte or word). After that, every data cycle with the select high goes to an internal address counter. The counter steps by itself after each access.

A host cycle is captured on the falling edge of chip select and classified by the write strobe, the read strobe and the data/command select. All host inputs are taken as already synchronous to `clk`. Reads are prefetched. The first read after an address setup returns a dummy value and starts the first internal fetch. Each later read returns the word fetched one access earlier and starts the next fetch. The internal bus has a fixed latency of one cycle, and the host cycle lasts several internal clocks, so the prefetched word is always ready in time. A command write during the data phase ends a read burst and restarts the address setup. The usual way to end a burst is a run of zero command words.

Top module: `host_ind_bridge`

## Requirements
- R1: After reset `hd_o` is 0x0000, `bus_req` is low and the setup sequence waits for a first command word.
- R2: A host cycle is taken once, on the clock after `cs_n` is first seen low following a high sample. The cycle is a write when `wr_n` is low, and a read when `rd_n` is low and `wr_n` is high. `dsel` low marks a command cycle and `dsel` high marks a data cycle. Each accepted data cycle produces exactly one single-cycle `bus_req` pulse.
- R3: First command word: bit 15 selects memory (1) or register space (0), bits 14..11 are ignored, and bits 10..0 become address bits 18..8.
- R4: Second command word: bits 15..8 become address bits 7..0. Bits 7..0 equal to 0x01 select word access, and any other value selects byte access. This word enters the data phase.
- R5: Each data access uses the counter value as `bus_addr`, then advances the counter by 1 in byte mode or by 2 in word mode.
- R6: In memory space, a step that would pass 0x3FFFF sends the counter to 0. A step from 0x3FFFF in byte mode or from 0x3FFFE in word mode therefore lands on 0. In register space the counter simply rolls over modulo 2^19.
- R7: The first data read after an address setup or after a data write returns 0x0000. Each later read returns the data fetched by the previous read, so the reads come back in address order.
- R8: In byte mode the read data is {0x00, the byte at the address}, and a write carries the byte in bits 7..0. In word mode, bits 7..0 hold the byte at the address and bits 15..8 hold the byte at the address plus 1.
- R9: A data cycle that arrives before both command words have been received makes no bus request. A read that is ignored, or a command read, returns 0x0000.
- R10: A command write during the data phase is taken as a new first command word. It ends any read burst, and the next read after the new setup is a dummy again.
- R11: A data write goes to the current counter value, which after reads points one past the last fetched location. A data write also re-arms the dummy read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| dsel | input | 1 | 1 = data cycle, 0 = command cycle |
| hd_i | input | 16 | Host write data |
| hd_o | output | 16 | Host read data |
| hd_oe | output | 1 | Host read data drive enable |
| bus_req | output | 1 | Internal access request pulse |
| bus_we | output | 1 | Request is a write |
| bus_mem | output | 1 | 1 = memory space, 0 = register space |
| bus_wide | output | 1 | 1 = word access, 0 = byte access |
| bus_addr | output | 19 | Internal access address |
| bus_wdata | output | 16 | Internal write data |
| bus_rdata | input | 16 | Internal read data, valid the cycle after a read request |

## Verification
A corrupted counter shows up at the port of the very next data access, as a wrong `bus_addr`. It also shows up as a wrong read value one access later, because reads are prefetched. A wrong phase or a lost dummy flag moves every later read by one position, or returns data where 0x0000 is due. The first read after a setup exposes it. Because writes and reads go through the same counter, a wrong step size or a wrong wrap point surfaces as a mismatched read-back, one host cycle after the faulty access.

// File: rtl/host_ind_bridge.sv
module host_ind_bridge #(
  parameter int AW = 19,
  parameter int DW = 16,
  parameter int unsigned MEM_TOP = 32'h3FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          dsel,
  input  logic [DW-1:0] hd_i,
  output logic [DW-1:0] hd_o,
  output logic          hd_oe,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_mem,
  output logic          bus_wide,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  localparam int HW = AW - 8;
  localparam logic [AW:0] TOP_X = (AW+1)'(MEM_TOP);
  localparam logic [7:0] WORD_CODE = 8'h01;

  typedef enum logic [1:0] {PH_HI, PH_LO, PH_DATA} ph_t;

  ph_t           phase;
  logic          cs_q, mem_q, wide, first, rd_pend;
  logic [AW-1:0] cnt, cnt_nx;
  logic [AW:0]   sum;
  logic [DW-1:0] pbuf;
  logic          stb, wr_stb, rd_stb, cmd_wr, dat_wr, dat_rd;

  assign stb    = cs_q & ~cs_n;
  assign wr_stb = stb & ~wr_n;
  assign rd_stb = stb & ~rd_n & wr_n;
  assign cmd_wr = wr_stb & ~dsel;
  assign dat_wr = wr_stb & dsel & (phase == PH_DATA);
  assign dat_rd = rd_stb & dsel & (phase == PH_DATA);

  assign sum    = {1'b0, cnt} + (wide ? (AW+1)'(2) : (AW+1)'(1));
  assign cnt_nx = (mem_q && sum > TOP_X) ? '0 : sum[AW-1:0];

  assign bus_mem  = mem_q;
  assign bus_wide = wide;
  assign hd_oe    = ~cs_n & ~rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      phase     <= PH_HI;
      mem_q     <= 1'b0;
      wide      <= 1'b0;
      first     <= 1'b1;
      cnt       <= '0;
      pbuf      <= '0;
      rd_pend   <= 1'b0;
      hd_o      <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      cs_q    <= cs_n;
      bus_req <= 1'b0;
      rd_pend <= bus_req & ~bus_we;
      if (rd_pend)
        pbuf <= wide ? bus_rdata : {{(DW-8){1'b0}}, bus_rdata[7:0]};

      if (cmd_wr) begin
        if (phase == PH_LO) begin
          cnt[7:0] <= hd_i[15:8];
          wide     <= (hd_i[7:0] == WORD_CODE);
          phase    <= PH_DATA;
          first    <= 1'b1;
        end else begin
          mem_q       <= hd_i[DW-1];
          cnt[AW-1:8] <= hd_i[HW-1:0];
          phase       <= PH_LO;
        end
      end

      if (dat_wr) begin
        bus_req   <= 1'b1;
        bus_we    <= 1'b1;
        bus_addr  <= cnt;
        bus_wdata <= hd_i;
        cnt       <= cnt_nx;
        first     <= 1'b1;
      end

      if (rd_stb) begin
        if (dat_rd) begin
          hd_o     <= first ? '0 : pbuf;
          bus_req  <= 1'b1;
          bus_we   <= 1'b0;
          bus_addr <= cnt;
          cnt      <= cnt_nx;
          first    <= 1'b0;
        end else begin
          hd_o <= '0;
        end
      end
    end
  end

  logic [AW:0] req_end;
  assign req_end = {1'b0, bus_addr} + (bus_wide ? (AW+1)'(2) : (AW+1)'(1));

  p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);

  p_req_in_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> phase == PH_DATA);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_mem && req_end > TOP_X) |-> cnt == '0);

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_mem && req_end > TOP_X)) |-> cnt == req_end[AW-1:0]);

  p_dummy_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_DATA) |-> first);

  p_ignored_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !rd_n && wr_n && phase != PH_DATA) |=> hd_o == '0);
endmodule

// File: tb/sim_host_ind_bridge.sv
module sim_host_ind_bridge;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, dsel = 1;
  logic [15:0] hd_i = '0, hd_o, bus_wdata, bus_rdata = '0;
  logic [18:0] bus_addr;
  logic hd_oe, bus_req, bus_we, bus_mem, bus_wide;

  always #5 clk = ~clk;

  host_ind_bridge u0 (.clk, .rst_n, .cs_n, .rd_n, .wr_n, .dsel, .hd_i, .hd_o, .hd_oe,
    .bus_req, .bus_we, .bus_mem, .bus_wide, .bus_addr, .bus_wdata, .bus_rdata);

  int tests = 0, fails = 0, nreq = 0;
  bit done = 0;

  // bench memory seen by the design
  logic [7:0] bm [int];
  function automatic logic [7:0] bm_get(int k);
    return bm.exists(k) ? bm[k] : 8'h00;
  endfunction
  always @(posedge clk) if (bus_req) begin
    int k;
    nreq++;
    k = (int'(bus_mem) << 20) | int'(bus_addr);
    if (bus_we) begin
      bm[k] = bus_wdata[7:0];
      if (bus_wide) bm[k+1] = bus_wdata[15:8];
    end else bus_rdata <= {bm_get(k+1), bm_get(k)};
  end

  // reference model
  logic [7:0] sh [int];
  int   m_phase = 0;
  bit   m_mem = 0, m_word = 0, m_first = 1;
  logic [18:0] m_cnt = '0;
  logic [15:0] m_pbuf = '0;

  function automatic logic [7:0] sh_get(int k);
    return sh.exists(k) ? sh[k] : 8'h00;
  endfunction
  function automatic int mkey(bit m, logic [18:0] a);
    return (int'(m) << 20) | int'(a);
  endfunction
  function automatic logic [18:0] m_next(logic [18:0] a, bit m, bit w);
    int s;
    s = int'(a) + (w ? 2 : 1);
    if (m && s > 32'h3FFFF) return '0;
    return 19'(s);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hcyc(bit is_dat, bit is_rd, logic [15:0] d, output logic [15:0] r);
    @(negedge clk);
    dsel = is_dat; rd_n = !is_rd; wr_n = is_rd; hd_i = d;
    @(negedge clk); cs_n = 0;
    repeat (5) @(negedge clk);
    r = hd_o;
    cs_n = 1; rd_n = 1; wr_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmd(logic [15:0] w);
    logic [15:0] r;
    hcyc(0, 0, w, r);
    if (m_phase == 1) begin
      m_cnt[7:0] = w[15:8]; m_word = (w[7:0] == 8'h01); m_phase = 2; m_first = 1;
    end else begin
      m_mem = w[15]; m_cnt[18:8] = w[10:0]; m_phase = 1;
    end
  endtask

  task automatic setup(bit m, logic [18:0] a, logic [7:0] mode);
    cmd({m, 4'b0, a[18:8]});
    cmd({a[7:0], mode});
  endtask

  task automatic dwr(logic [15:0] d, string tag);
    logic [15:0] r; int n0, k;
    n0 = nreq;
    hcyc(1, 0, d, r);
    if (m_phase == 2) begin
      k = mkey(m_mem, m_cnt);
      sh[k] = d[7:0];
      if (m_word) sh[k+1] = d[15:8];
      m_cnt = m_next(m_cnt, m_mem, m_word); m_first = 1;
      chk({tag, " R2 one request per data write"}, nreq - n0, 1);
    end else chk({tag, " R9 write ignored before setup"}, nreq - n0, 0);
  endtask

  task automatic drd(string tag);
    logic [15:0] r, e; int n0, k;
    n0 = nreq;
    hcyc(1, 1, 16'hFFFF, r);
    if (m_phase != 2) begin
      chk({tag, " R9 ignored read data"}, r, 0);
      chk({tag, " R9 ignored read no request"}, nreq - n0, 0);
      return;
    end
    e = m_first ? 16'h0000 : m_pbuf;
    k = mkey(m_mem, m_cnt);
    m_pbuf = m_word ? {sh_get(k+1), sh_get(k)} : {8'h00, sh_get(k)};
    m_cnt = m_next(m_cnt, m_mem, m_word); m_first = 0;
    chk({tag, " R7 R8 read data"}, r, e);
    chk({tag, " R2 one request per data read"}, nreq - n0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset hd_o", hd_o, 0);
    chk("R1 reset bus_req", bus_req, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    dwr(16'h1234, "R9 pre-setup");
    drd("R9 pre-setup");
    cmd(16'h8000);
    drd("R9 half setup");
    cmd(16'h0001);

    setup(1, 19'h00100, 8'h01);
    dwr(16'hA1B2, "R5 word"); dwr(16'hC3D4, "R5 word"); dwr(16'hE5F6, "R5 word");
    setup(1, 19'h00100, 8'h01);
    drd("R7 dummy"); drd("R5 word"); drd("R5 word"); drd("R5 word");
    chk("R5 word step", m_cnt, 19'h00108);

    setup(1, 19'h00101, 8'h00);
    drd("R8 byte dummy"); drd("R8 byte hi"); drd("R8 byte next");
    setup(1, 19'h00200, 8'h02);
    dwr(16'hFF5A, "R4 mode 02 byte"); dwr(16'h77A5, "R8 byte");
    setup(1, 19'h00200, 8'h01);
    drd("R4 dummy"); drd("R4 R8 word view of bytes");

    setup(1, 19'h3FFFE, 8'h01);
    dwr(16'h1357, "R6 word top"); dwr(16'h2468, "R6 word wrap");
    chk("R6 word wrap point", m_cnt, 19'h00002);
    setup(1, 19'h00000, 8'h01);
    drd("R6 dummy"); drd("R6 wrapped word");
    setup(1, 19'h3FFFF, 8'h00);
    dwr(16'h00C7, "R6 byte top"); dwr(16'h00D8, "R6 byte wrap");
    setup(1, 19'h3FFFF, 8'h00);
    drd("R6 dummy"); drd("R6 top byte"); drd("R6 byte after wrap");

    setup(0, 19'h3FFFF, 8'h00);
    dwr(16'h0011, "R6 reg top"); dwr(16'h0022, "R6 reg no wrap");
    chk("R6 reg counter", m_cnt, 19'h40001);
    setup(0, 19'h40000, 8'h00);
    drd("R6 dummy"); drd("R6 reg 40000");

    cmd(16'hF801); cmd(16'h0001);
    dwr(16'h9ABC, "R3 ignored bits");
    setup(1, 19'h00100, 8'h01);
    drd("R3 dummy"); drd("R3 alias check");

    setup(1, 19'h00100, 8'h01);
    drd("R10 dummy"); drd("R10 burst");
    cmd(16'h0000);
    drd("R10 after terminate");
    cmd(16'h0000);
    drd("R10 dummy after restart"); drd("R10 reg read");

    setup(1, 19'h00100, 8'h01);
    drd("R11 dummy"); drd("R11 read");
    dwr(16'h4455, "R11 write after read");
    drd("R11 rearmed dummy"); drd("R11 read after write");

    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 99);
      if (sel < 10) begin
        logic [18:0] a; bit m;
        m = $urandom_range(0, 3) != 0;
        a = {($urandom_range(0, 2) == 0) ? 11'h3FF : 11'(($urandom_range(0, 1))),
             8'($urandom_range(0, 255))};
        if ($urandom_range(0, 3) == 0) a[7:0] = 8'hFC + 8'($urandom_range(0, 3));
        setup(m, a, ($urandom_range(0, 5) == 0) ? 8'($urandom_range(2, 255)) : 8'($urandom_range(0, 1)));
      end else if (sel < 13) cmd(16'($urandom_range(0, 65535)));
      else if (sel < 55) dwr(16'($urandom_range(0, 65535)), "R5 R11 random write");
      else drd("R7 R8 random read");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule